// File: doc/BRIEF.md
# Sticky Interrupt Status Register Bank

This block collects interrupt causes from an environmental monitor: temperature limits, voltage limits, fan limits and sensor-diode faults. It keeps them in three 8-bit sticky status registers. Each cause arrives on two wires. One is a single-cycle event pulse, raised when a conversion finds a violation or fault. The other is a level that stays high while the cause is still present. A set status bit holds until the host reads its register. The read then clears only those bits whose cause has gone away, so a condition that is still active cannot be lost by a read.

The host also owns three enable registers, one per status register and one bit per cause. An event whose enable bit is zero never reaches its status bit. A set status bit pulls the active-low interrupt pin only while its enable bit is one. The host port is a plain strobe interface: a read strobe, a write strobe, an address and the write data. Read data comes back in the same cycle as the strobe.

Top module: `irq_status_bank`

## Requirements
- R1: After reset, all status registers and all enable registers read 0x00 and `irq_n_o` is high.
- R2: An event pulse on `evt_i[8*k+i]` while enable bit i of register k is 1 sets status bit i of register k on the next clock edge. The bit then stays set until that status register is read.
- R3: On a read of status register k, each set bit whose `src_act_i[8*k+i]` is low in the strobe cycle clears on the next edge. Each set bit whose source is high stays set.
- R4: `host_rdata_o` shows the addressed register in the same cycle as `host_rd_i`, with status bits at their value before any clear. It is 0x00 when no read is strobed.
- R5: A write to a status address (0..2) has no effect on any status register.
- R6: An event whose enable bit is 0 never sets its status bit.
- R7: If an enabled event arrives in the same cycle as a read that would clear its bit, the bit is set after that edge.
- R8: Address map, 3-bit address: status register k at address k, enable register k at address 4+k, where k=0 covers temperature, k=1 voltage and k=2 fan and diode. Writes to addresses 4..6 load the enable register and reads return it. Addresses 3 and 7 read 0x00 and ignore writes.
- R9: `irq_n_o` is a register. It is low in the cycle after any status bit is set together with its enable bit, and high in the cycle after no such pair exists.
- R10: Reading one status register never changes another status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 24 | Single-cycle event pulses, bit 8*k+i for status register k bit i |
| src_act_i | input | 24 | Cause-still-active levels, same bit layout as `evt_i` |
| host_rd_i | input | 1 | Read strobe |
| host_wr_i | input | 1 | Write strobe |
| host_addr_i | input | 3 | Register address |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data, valid while `host_rd_i` is high |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Assertions watch the status flops on every cycle. A set bit survives any cycle without a read of its register. A read leaves every bit whose source is still active. No bit rises without an enabled event. An enabled event always leaves its bit set, even with a read in the same cycle. The pin is checked against the pending status-and-enable pairs one cycle earlier.

Only the bench scenarios can show the rest. They cover the pre-clear read value, writes to status addresses being ignored, the unused addresses, and the isolation between registers. A second read confirms the effect of the first, and a long random run is compared against a behavioural model.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;

  // Top address bit selects the bank: status or enable.
  typedef enum logic {
    BANK_STATUS = 1'b0,
    BANK_ENABLE = 1'b1
  } bank_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irq_addr_dec.sv
`timescale 1ns/1ps
module irq_addr_dec
  import irq_bank_pkg::*;
#(
  parameter  int unsigned NUM_REGS = 3,
  localparam int unsigned IDX_W    = idx_width(NUM_REGS),
  localparam int unsigned ADDR_W   = IDX_W + 1
) (
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_REGS-1:0] rd_stat_o,
  output logic [NUM_REGS-1:0] rd_enb_o,
  output logic [NUM_REGS-1:0] wr_enb_o
);

  bank_e            bank;
  logic [IDX_W-1:0] idx;

  assign bank = bank_e'(addr_i[ADDR_W-1]);
  assign idx  = addr_i[IDX_W-1:0];

  // Writes to the status bank have no target, so they vanish here.
  always_comb begin
    rd_stat_o = '0;
    rd_enb_o  = '0;
    wr_enb_o  = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) begin
        rd_stat_o[i] = rd_i && (bank == BANK_STATUS);
        rd_enb_o[i]  = rd_i && (bank == BANK_ENABLE);
        wr_enb_o[i]  = wr_i && (bank == BANK_ENABLE);
      end
    end
  end

endmodule

// File: rtl/irq_status_reg.sv
`timescale 1ns/1ps
module irq_status_reg #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] evt_i,
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] en_i,
  input  logic             rd_hit_i,
  output logic [REG_W-1:0] status_o
);

  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] status_d;
  logic [REG_W-1:0] set_v;
  logic [REG_W-1:0] keep_v;
  logic             upd;

  // Next state: the read clears causes that are gone; new events always win.
  always_comb begin
    set_v    = evt_i & en_i;
    keep_v   = rd_hit_i ? (status_q & src_i) : status_q;
    status_d = keep_v | set_v;
    upd      = rd_hit_i | (|set_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (upd) begin
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit_i |=> ((status_q & $past(status_q)) == $past(status_q))); // R2

  AST_READ_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_i |=> ((status_q & $past(status_q & src_i)) == $past(status_q & src_i))); // R3

  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i & en_i)) == '0)); // R6

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & en_i)) |=> ((status_q & $past(evt_i & en_i)) == $past(evt_i & en_i))); // R7

endmodule

// File: rtl/irq_enable_reg.sv
`timescale 1ns/1ps
module irq_enable_reg #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_o
);

  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] en_d;

  always_comb begin
    en_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_hit_i) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/irq_read_mux.sv
`timescale 1ns/1ps
module irq_read_mux #(
  parameter  int unsigned NUM_REGS = 3,
  parameter  int unsigned REG_W    = 8,
  localparam int unsigned FLAT_W   = NUM_REGS * REG_W
) (
  input  logic [NUM_REGS-1:0] sel_stat_i,
  input  logic [NUM_REGS-1:0] sel_enb_i,
  input  logic [FLAT_W-1:0]   stat_i,
  input  logic [FLAT_W-1:0]   enb_i,
  output logic [REG_W-1:0]    rdata_o
);

  // AND-OR selection: no selected register gives zero.
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      rdata_o |= ({REG_W{sel_stat_i[i]}} & stat_i[i*REG_W +: REG_W])
               | ({REG_W{sel_enb_i[i]}}  & enb_i[i*REG_W +: REG_W]);
    end
  end

endmodule

// File: rtl/irq_pin.sv
`timescale 1ns/1ps
module irq_pin #(
  parameter int unsigned FLAT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAT_W-1:0] stat_i,
  input  logic [FLAT_W-1:0] enb_i,
  output logic              irq_n_o
);

  logic irq_n_q;
  logic irq_n_d;

  always_comb begin
    irq_n_d = ~(|(stat_i & enb_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n_q <= 1'b1;
    end else begin
      irq_n_q <= irq_n_d;
    end
  end

  assign irq_n_o = irq_n_q;

endmodule

// File: rtl/irq_status_bank.sv
`timescale 1ns/1ps
module irq_status_bank
  import irq_bank_pkg::*;
#(
  parameter  int unsigned NUM_REGS = 3,
  parameter  int unsigned REG_W    = 8,
  localparam int unsigned IDX_W    = idx_width(NUM_REGS),
  localparam int unsigned ADDR_W   = IDX_W + 1,
  localparam int unsigned FLAT_W   = NUM_REGS * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAT_W-1:0] evt_i,
  input  logic [FLAT_W-1:0] src_act_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [REG_W-1:0]  host_wdata_i,
  output logic [REG_W-1:0]  host_rdata_o,
  output logic              irq_n_o
);

  logic [NUM_REGS-1:0] rd_stat;
  logic [NUM_REGS-1:0] rd_enb;
  logic [NUM_REGS-1:0] wr_enb;
  logic [FLAT_W-1:0]   stat_flat;
  logic [FLAT_W-1:0]   enb_flat;

  irq_addr_dec #(.NUM_REGS(NUM_REGS)) u_dec (
    .rd_i      (host_rd_i),
    .wr_i      (host_wr_i),
    .addr_i    (host_addr_i),
    .rd_stat_o (rd_stat),
    .rd_enb_o  (rd_enb),
    .wr_enb_o  (wr_enb)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    irq_enable_reg #(.REG_W(REG_W)) u_enb (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit_i (wr_enb[k]),
      .wdata_i  (host_wdata_i),
      .en_o     (enb_flat[k*REG_W +: REG_W])
    );

    irq_status_reg #(.REG_W(REG_W)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i[k*REG_W +: REG_W]),
      .src_i    (src_act_i[k*REG_W +: REG_W]),
      .en_i     (enb_flat[k*REG_W +: REG_W]),
      .rd_hit_i (rd_stat[k]),
      .status_o (stat_flat[k*REG_W +: REG_W])
    );
  end

  irq_read_mux #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_mux (
    .sel_stat_i (rd_stat),
    .sel_enb_i  (rd_enb),
    .stat_i     (stat_flat),
    .enb_i      (enb_flat),
    .rdata_o    (host_rdata_o)
  );

  irq_pin #(.FLAT_W(FLAT_W)) u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_i  (stat_flat),
    .enb_i   (enb_flat),
    .irq_n_o (irq_n_o)
  );

  AST_IRQ_LOW_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_flat & enb_flat)) |=> !irq_n_o); // R9

  AST_IRQ_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_flat & enb_flat)) |=> irq_n_o); // R9

endmodule

// File: tb/irq_status_bank_tb.sv
`timescale 1ns/1ps
module irq_status_bank_tb;

  logic        clk;
  logic        rst_n;
  logic [23:0] evt;
  logic [23:0] src;
  logic        rd;
  logic        wr;
  logic [2:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Behavioural model
  logic [7:0] m_stat [3];
  logic [7:0] m_en   [3];
  logic       m_irq_n;

  irq_status_bank u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt),
    .src_act_i    (src),
    .host_rd_i    (rd),
    .host_wr_i    (wr),
    .host_addr_i  (addr),
    .host_wdata_i (wdata),
    .host_rdata_o (rdata),
    .irq_n_o      (irq_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [2:0] a);
    if (a[1:0] == 2'd3) return 8'h00;
    return a[2] ? m_en[a[1:0]] : m_stat[a[1:0]];
  endfunction

  // One clock: drive at negedge, check, then advance model at posedge.
  task automatic step(input logic [23:0] e, input logic [23:0] s, input logic r,
                      input logic w, input logic [2:0] a, input logic [7:0] wd,
                      input string tag);
    logic [7:0] pend;
    logic [7:0] nstat [3];
    @(negedge clk);
    evt = e; src = s; rd = r; wr = w; addr = a; wdata = wd;
    #1;
    check("R9 irq_n", {7'd0, irq_n}, {7'd0, m_irq_n});
    check({tag, " rdata"}, rdata, r ? model_read(a) : 8'h00);
    @(posedge clk);
    pend = '0;
    for (int k = 0; k < 3; k++) pend |= m_stat[k] & m_en[k];
    for (int k = 0; k < 3; k++) begin
      nstat[k] = (r && !a[2] && a[1:0] == k[1:0]) ? (m_stat[k] & s[k*8 +: 8]) : m_stat[k];
      nstat[k] |= e[k*8 +: 8] & m_en[k];
    end
    for (int k = 0; k < 3; k++) m_stat[k] = nstat[k];
    if (w && a[2] && a[1:0] != 2'd3) m_en[a[1:0]] = wd;
    m_irq_n = (pend == 8'h00);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, 1'b0, 1'b0, 3'd0, 8'h00, "idle");
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [23:0] s, input string tag);
    step('0, s, 1'b1, 1'b0, a, 8'h00, tag);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    step('0, '0, 1'b0, 1'b1, a, d, "wr");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    evt = '0; src = '0; rd = 0; wr = 0; addr = '0; wdata = '0;
    for (int k = 0; k < 3; k++) begin m_stat[k] = '0; m_en[k] = '0; end
    m_irq_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: all registers zero after reset
    for (int a = 0; a < 8; a++) rd_reg(3'(a), '0, "R1");

    // R8: enables writable and readable, holes ignore writes
    wr_reg(3'd4, 8'hFF);
    wr_reg(3'd5, 8'h0F);
    wr_reg(3'd6, 8'h00);
    wr_reg(3'd7, 8'hAA);
    wr_reg(3'd3, 8'h55);
    rd_reg(3'd4, '0, "R8");
    rd_reg(3'd5, '0, "R8");
    rd_reg(3'd6, '0, "R8");
    rd_reg(3'd7, '0, "R8");
    rd_reg(3'd3, '0, "R8");

    // R6: disabled event on register 2, and on high nibble of register 1
    step(24'hFF_F0_00, '0, 0, 0, 3'd0, 8'h00, "R6");
    idle(2);
    rd_reg(3'd2, '0, "R6");
    rd_reg(3'd1, '0, "R6");

    // R2/R4/R3: enabled pulse, source gone, sticky then cleared by read
    step(24'h00_00_08, '0, 0, 0, 3'd0, 8'h00, "R2");
    idle(4);
    rd_reg(3'd0, '0, "R4 pre-clear");
    rd_reg(3'd0, '0, "R3 cleared");

    // R3: source still active across a read
    step(24'h00_00_20, 24'h00_00_20, 0, 0, 3'd0, 8'h00, "R2");
    rd_reg(3'd0, 24'h00_00_20, "R3 active");
    rd_reg(3'd0, 24'h00_00_20, "R3 still set");
    rd_reg(3'd0, '0, "R3 last");
    rd_reg(3'd0, '0, "R3 gone");

    // R5: writes to status addresses ignored
    step(24'h00_00_81, '0, 0, 0, 3'd0, 8'h00, "R2");
    wr_reg(3'd0, 8'h00);
    wr_reg(3'd1, 8'hFF);
    rd_reg(3'd1, '0, "R5 reg1");
    rd_reg(3'd0, '0, "R5 reg0");
    rd_reg(3'd0, '0, "R5 reg0 clear");

    // R7: event coincident with a clearing read
    step(24'h00_00_02, '0, 0, 0, 3'd0, 8'h00, "R2");
    step(24'h00_00_02, '0, 1, 0, 3'd0, 8'h00, "R7 read");
    rd_reg(3'd0, '0, "R7 kept");
    rd_reg(3'd0, '0, "R7 cleared");

    // R10: reading register 1 leaves register 0 alone
    step(24'h00_03_40, '0, 0, 0, 3'd0, 8'h00, "R2");
    rd_reg(3'd1, '0, "R10 read r1");
    rd_reg(3'd0, '0, "R10 r0 intact");
    rd_reg(3'd1, '0, "R10 r1 cleared");

    // R9: disabling enable releases pin while status stays set
    step(24'h00_00_04, '0, 0, 0, 3'd0, 8'h00, "R9");
    idle(2);
    wr_reg(3'd4, 8'h00);
    idle(2);
    wr_reg(3'd4, 8'h04);
    idle(2);
    rd_reg(3'd0, '0, "R9 status");
    idle(2);

    // Random phase against the model
    for (int i = 0; i < 600; i++) begin
      logic [23:0] e;
      logic [23:0] s;
      logic        r;
      logic        w;
      e = 24'($urandom) & 24'($urandom) & 24'($urandom);
      s = 24'($urandom) & 24'($urandom);
      r = ($urandom_range(0, 2) == 0);
      w = !r && ($urandom_range(0, 7) == 0);
      step(e, s, r, w, 3'($urandom), 8'($urandom), "R2 R3 R7 random");
    end
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule